// File: doc/BRIEF.md
# Segment Descriptor Cache

This block holds recently used segment descriptors for a memory management unit, so that address translation can skip the table walk when a descriptor is already on chip. The storage is direct-mapped and divided into sections, with a fixed number of entries in each section. The section field and the segment field of a virtual address select exactly one entry. That entry keeps a tag, a good flag, a modified flag and the two descriptor words, split into a low half and a high half.

The translation pipeline sends a lookup and gets a registered hit/miss response with both descriptor words one cycle later. After a table walk, the walker writes a descriptor through the fill port. Software-driven maintenance uses three invalidation ports: one for the entry that an address selects, one for a whole section and one for every section. When the pipeline writes to a segment, it asks for the modified flag to be set. A request to set the referenced flag is accepted but changes nothing, because the cache does not store that flag.

Top module: `seg_desc_cache`

## Requirements
- R1: After reset every entry is invalid, so each lookup misses until that entry is filled.
- R2: The virtual address is laid out as {section[1:0], segment[2:0], tag[9:0]}, with the section in the most significant bits. It selects entry section*8 + segment. The selector inputs of the invalidate and modified-flag ports carry only {section, segment}.
- R3: A lookup hits only when the selected entry is good and its stored tag equals the tag of the address. On a hit the response returns descriptor words 0 and 1. On a miss both words are zero.
- R4: rsp_valid is high in exactly the cycle after a cycle with lk_req high. The response reflects the contents as they were before any update made in the cycle of the request.
- R5: A fill stores the tag and both words into the selected entry and marks it good. Bit 1 of word 0 is the modified flag, and its initial value comes from the filled word.
- R6: An address invalidate clears the good flag of the selected entry whatever tag it holds.
- R7: A section invalidate clears every entry of the given section and leaves the other sections alone.
- R8: A full invalidate clears every entry.
- R9: A modified-flag request (mark_kind = 0) sets bit 1 of word 0 in the selected entry whatever tag that entry holds, and the bit stays set until the next fill.
- R10: A referenced-flag request (mark_kind = 1) changes nothing in the cache.
- R11: When a fill and any invalidate that covers the same entry arrive in the same cycle, the entry ends up invalid.
- R12: When a fill and a modified-flag request select the same entry in the same cycle, the entry ends up good with bit 1 of word 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 15 | Lookup address {section, segment, tag} |
| rsp_valid | output | 1 | Response strobe, one cycle after lk_req |
| rsp_hit | output | 1 | Lookup hit |
| rsp_word0 | output | 32 | Descriptor word 0 (zero on miss) |
| rsp_word1 | output | 32 | Descriptor word 1 (zero on miss) |
| fill_en | input | 1 | Fill request |
| fill_va | input | 15 | Fill address {section, segment, tag} |
| fill_word0 | input | 32 | Descriptor word 0 to store |
| fill_word1 | input | 32 | Descriptor word 1 to store |
| inv_addr_en | input | 1 | Invalidate the selected entry |
| inv_addr_sel | input | 5 | {section, segment} of the address to invalidate |
| inv_sec_en | input | 1 | Invalidate one section |
| inv_sec_id | input | 2 | Section to invalidate |
| inv_all_en | input | 1 | Invalidate all sections |
| mark_en | input | 1 | Flag-set request |
| mark_sel | input | 5 | {section, segment} of the entry to mark |
| mark_kind | input | 1 | 0 = modified flag, 1 = referenced flag |

## Verification
Updates from fill, invalidate and flag-set requests take effect at the edge that samples them, so a lookup issued in the following cycle sees them. A lookup response is due exactly one cycle after its request and reflects the state from before that request's own cycle. The bench keeps a behavioural model that it updates at every rising edge. The model first computes the response due from its state before the update, then applies fill, modified flag and invalidates in that order. At the next falling edge the model's response is compared with the outputs. Directed checks read the response right after the edge that follows the lookup cycle.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    // Kind of flag-set request arriving on the mark port.
    typedef enum logic {
        MARK_MODIFIED   = 1'b0,
        MARK_REFERENCED = 1'b1
    } sdc_mark_e;

    // Per-entry update command produced by the decoder.
    typedef struct packed {
        logic fill;   // write tag, words and set good
        logic kill;   // clear good (any invalidate kind)
        logic mark;   // set modified flag
    } sdc_cmd_t;

    // Entry selection: section-major flat index.
    function automatic int unsigned sdc_flat_index(
        input int unsigned sec,
        input int unsigned seg,
        input int unsigned per_sec
    );
        return sec * per_sec + seg;
    endfunction

endpackage

// File: rtl/sdc_sel_index.sv
module sdc_sel_index #(
    parameter int SEC_W = 2,
    parameter int SEG_W = 3,
    parameter int ENTRIES = 8,
    parameter int IDX_W = 5
) (
    input  logic [SEC_W+SEG_W-1:0] sel,
    output logic [IDX_W-1:0]       idx
);
    logic [SEC_W-1:0] sec;
    logic [SEG_W-1:0] seg;

    assign sec = sel[SEC_W+SEG_W-1:SEG_W];
    assign seg = sel[SEG_W-1:0];
    assign idx = IDX_W'(sdc_pkg::sdc_flat_index(int'(sec), int'(seg), ENTRIES));
endmodule

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
    import sdc_pkg::*;
#(
    parameter int SECTIONS = 4,
    parameter int ENTRIES = 8,
    parameter int SEC_W = 2,
    parameter int IDX_W = 5
) (
    input  logic                  fill_en,
    input  logic [IDX_W-1:0]      fill_idx,
    input  logic                  inv_addr_en,
    input  logic [IDX_W-1:0]      inv_addr_idx,
    input  logic                  inv_sec_en,
    input  logic [SEC_W-1:0]      inv_sec_id,
    input  logic                  inv_all_en,
    input  logic                  mark_en,
    input  sdc_mark_e             mark_kind,
    input  logic [IDX_W-1:0]      mark_idx,
    output sdc_cmd_t [SECTIONS*ENTRIES-1:0] cmd_vec
);
    localparam int DEPTH = SECTIONS * ENTRIES;

    logic mark_mod;
    assign mark_mod = mark_en && (mark_kind == MARK_MODIFIED);

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        localparam int SEC_OF = e / ENTRIES;
        logic hit_addr, hit_sec;

        assign hit_addr = inv_addr_en && (inv_addr_idx == IDX_W'(e));
        assign hit_sec  = inv_sec_en && (inv_sec_id == SEC_W'(SEC_OF));

        assign cmd_vec[e].fill = fill_en && (fill_idx == IDX_W'(e));
        assign cmd_vec[e].kill = inv_all_en || hit_sec || hit_addr;
        assign cmd_vec[e].mark = mark_mod && (mark_idx == IDX_W'(e));
    end
endmodule

// File: rtl/sdc_entry_array.sv
module sdc_entry_array
    import sdc_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LO_W = 18,
    parameter int HI_W = 56
) (
    input  logic                        clk,
    input  logic                        rst,
    input  sdc_cmd_t [DEPTH-1:0]        cmd_vec,
    input  logic [LO_W-1:0]             fill_lo,
    input  logic [HI_W-1:0]             fill_hi,
    input  logic                        fill_m,
    output logic [DEPTH-1:0]            good_vec,
    output logic [DEPTH-1:0]            m_vec,
    output logic [DEPTH-1:0][LO_W-1:0]  lo_arr,
    output logic [DEPTH-1:0][HI_W-1:0]  hi_arr
);
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic            good_q, m_q;
        logic [LO_W-1:0] lo_q;
        logic [HI_W-1:0] hi_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                good_q <= 1'b0;
                m_q    <= 1'b0;
                lo_q   <= '0;
                hi_q   <= '0;
            end else begin
                if (cmd_vec[e].fill) begin
                    lo_q <= fill_lo;
                    hi_q <= fill_hi;
                end
                // invalidate dominates fill
                good_q <= cmd_vec[e].kill ? 1'b0 : (cmd_vec[e].fill ? 1'b1 : good_q);
                // a mark in the same cycle as a fill still lands
                m_q    <= cmd_vec[e].mark | (cmd_vec[e].fill ? fill_m : m_q);
            end
        end

        assign good_vec[e] = good_q;
        assign m_vec[e]    = m_q;
        assign lo_arr[e]   = lo_q;
        assign hi_arr[e]   = hi_q;

        AST_KILL_BEATS_FILL: assert property (@(posedge clk) disable iff (rst)
            (cmd_vec[e].fill && cmd_vec[e].kill) |=> !good_q); // R11
        AST_FILL_MAKES_GOOD: assert property (@(posedge clk) disable iff (rst)
            (cmd_vec[e].fill && !cmd_vec[e].kill) |=> good_q); // R5
        AST_MARK_SETS_M: assert property (@(posedge clk) disable iff (rst)
            cmd_vec[e].mark |=> m_q); // R9
    end
endmodule

// File: rtl/sdc_lookup.sv
module sdc_lookup #(
    parameter int DEPTH = 32,
    parameter int IDX_W = 5,
    parameter int TAG_W = 10,
    parameter int W0_W = 32,
    parameter int W1_W = 32,
    parameter int W0_LO_W = 8,
    parameter int M_POS = 1
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     lk_req,
    input  logic [IDX_W-1:0]                         lk_idx,
    input  logic [TAG_W-1:0]                         lk_tag,
    input  logic [DEPTH-1:0]                         good_vec,
    input  logic [DEPTH-1:0]                         m_vec,
    input  logic [DEPTH-1:0][TAG_W+W0_LO_W-1:0]      lo_arr,
    input  logic [DEPTH-1:0][W0_W-W0_LO_W+W1_W-1:0]  hi_arr,
    output logic                                     rsp_valid,
    output logic                                     rsp_hit,
    output logic [W0_W-1:0]                          rsp_word0,
    output logic [W1_W-1:0]                          rsp_word1
);
    localparam int LO_W = TAG_W + W0_LO_W;
    localparam int HI_W = W0_W - W0_LO_W + W1_W;
    localparam logic [W0_W-1:0] M_MASK = W0_W'(1) << M_POS;

    logic [LO_W-1:0] lo_sel;
    logic [HI_W-1:0] hi_sel;
    logic [W0_W-1:0] word0_c;
    logic [W1_W-1:0] word1_c;
    logic            hit_c;

    always_comb begin
        lo_sel  = lo_arr[lk_idx];
        hi_sel  = hi_arr[lk_idx];
        hit_c   = good_vec[lk_idx] && (lo_sel[LO_W-1 -: TAG_W] == lk_tag);
        word0_c = {hi_sel[HI_W-1 -: W0_W-W0_LO_W], lo_sel[W0_LO_W-1:0]};
        if (m_vec[lk_idx]) word0_c = word0_c | M_MASK;
        word1_c = hi_sel[W1_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_word0 <= '0;
            rsp_word1 <= '0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && hit_c;
            rsp_word0 <= (lk_req && hit_c) ? word0_c : '0;
            rsp_word1 <= (lk_req && hit_c) ? word1_c : '0;
        end
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_valid); // R4
    AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !rsp_valid); // R4
    AST_MISS_ZERO_WORDS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_word0 == '0 && rsp_word1 == '0)); // R3
    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid); // R3
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
    import sdc_pkg::*;
#(
    parameter int SECTIONS = 4,
    parameter int ENTRIES = 8,
    parameter int TAG_W = 10,
    parameter int W0_W = 32,
    parameter int W1_W = 32,
    parameter int W0_LO_W = 8,
    parameter int M_POS = 1,
    localparam int SEC_W = (SECTIONS > 1) ? $clog2(SECTIONS) : 1,
    localparam int SEG_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int SEL_W = SEC_W + SEG_W,
    localparam int VA_W = SEL_W + TAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_va,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [W0_W-1:0]  rsp_word0,
    output logic [W1_W-1:0]  rsp_word1,
    input  logic             fill_en,
    input  logic [VA_W-1:0]  fill_va,
    input  logic [W0_W-1:0]  fill_word0,
    input  logic [W1_W-1:0]  fill_word1,
    input  logic             inv_addr_en,
    input  logic [SEL_W-1:0] inv_addr_sel,
    input  logic             inv_sec_en,
    input  logic [SEC_W-1:0] inv_sec_id,
    input  logic             inv_all_en,
    input  logic             mark_en,
    input  logic [SEL_W-1:0] mark_sel,
    input  logic             mark_kind
);
    localparam int DEPTH = SECTIONS * ENTRIES;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LO_W  = TAG_W + W0_LO_W;
    localparam int HI_W  = W0_W - W0_LO_W + W1_W;
    localparam logic [DEPTH-1:0] SEC_MASK = DEPTH'({ENTRIES{1'b1}});

    logic [IDX_W-1:0] lk_idx, fill_idx, inv_idx, mark_idx;
    logic [TAG_W-1:0] lk_tag, fill_tag;
    sdc_cmd_t [DEPTH-1:0] cmd_vec;
    logic [DEPTH-1:0] good_vec, m_vec;
    logic [DEPTH-1:0][LO_W-1:0] lo_arr;
    logic [DEPTH-1:0][HI_W-1:0] hi_arr;
    sdc_mark_e mark_kind_e;

    assign lk_tag      = lk_va[TAG_W-1:0];
    assign fill_tag    = fill_va[TAG_W-1:0];
    assign mark_kind_e = sdc_mark_e'(mark_kind);

    sdc_sel_index #(.SEC_W(SEC_W), .SEG_W(SEG_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W))
        u_idx_lk   (.sel(lk_va[VA_W-1:TAG_W]),   .idx(lk_idx));
    sdc_sel_index #(.SEC_W(SEC_W), .SEG_W(SEG_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W))
        u_idx_fill (.sel(fill_va[VA_W-1:TAG_W]), .idx(fill_idx));
    sdc_sel_index #(.SEC_W(SEC_W), .SEG_W(SEG_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W))
        u_idx_inv  (.sel(inv_addr_sel),          .idx(inv_idx));
    sdc_sel_index #(.SEC_W(SEC_W), .SEG_W(SEG_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W))
        u_idx_mark (.sel(mark_sel),              .idx(mark_idx));

    sdc_cmd_decode #(.SECTIONS(SECTIONS), .ENTRIES(ENTRIES), .SEC_W(SEC_W), .IDX_W(IDX_W)) u_dec (
        .fill_en      (fill_en),
        .fill_idx     (fill_idx),
        .inv_addr_en  (inv_addr_en),
        .inv_addr_idx (inv_idx),
        .inv_sec_en   (inv_sec_en),
        .inv_sec_id   (inv_sec_id),
        .inv_all_en   (inv_all_en),
        .mark_en      (mark_en),
        .mark_kind    (mark_kind_e),
        .mark_idx     (mark_idx),
        .cmd_vec      (cmd_vec)
    );

    sdc_entry_array #(.DEPTH(DEPTH), .LO_W(LO_W), .HI_W(HI_W)) u_arr (
        .clk      (clk),
        .rst      (rst),
        .cmd_vec  (cmd_vec),
        .fill_lo  ({fill_tag, fill_word0[W0_LO_W-1:0]}),
        .fill_hi  ({fill_word0[W0_W-1:W0_LO_W], fill_word1}),
        .fill_m   (fill_word0[M_POS]),
        .good_vec (good_vec),
        .m_vec    (m_vec),
        .lo_arr   (lo_arr),
        .hi_arr   (hi_arr)
    );

    sdc_lookup #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .TAG_W(TAG_W), .W0_W(W0_W),
        .W1_W(W1_W), .W0_LO_W(W0_LO_W), .M_POS(M_POS)
    ) u_lk (
        .clk       (clk),
        .rst       (rst),
        .lk_req    (lk_req),
        .lk_idx    (lk_idx),
        .lk_tag    (lk_tag),
        .good_vec  (good_vec),
        .m_vec     (m_vec),
        .lo_arr    (lo_arr),
        .hi_arr    (hi_arr),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_word0 (rsp_word0),
        .rsp_word1 (rsp_word1)
    );

    AST_RESET_ALL_INVALID: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (good_vec == '0)); // R1
    AST_FLUSH_ALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        inv_all_en |=> (good_vec == '0)); // R8
    AST_SECTION_CLEARS: assert property (@(posedge clk) disable iff (rst)
        inv_sec_en |=> ((good_vec >> (int'($past(inv_sec_id)) * ENTRIES)) & SEC_MASK) == '0); // R7
    AST_ADDR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        inv_addr_en |=> !good_vec[$past(inv_idx)]); // R6
    AST_REF_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (mark_en && mark_kind_e == MARK_REFERENCED && !fill_en) |=> $stable(m_vec)); // R10
endmodule

// File: tb/tb_seg_desc_cache.sv
`timescale 1ns/1ps
module tb_seg_desc_cache;
    localparam int NE = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 0;
    logic [14:0] lk_va = 0;
    logic        rsp_valid, rsp_hit;
    logic [31:0] rsp_word0, rsp_word1;
    logic        fill_en = 0;
    logic [14:0] fill_va = 0;
    logic [31:0] fill_word0 = 0, fill_word1 = 0;
    logic        inv_addr_en = 0;
    logic [4:0]  inv_addr_sel = 0;
    logic        inv_sec_en = 0;
    logic [1:0]  inv_sec_id = 0;
    logic        inv_all_en = 0;
    logic        mark_en = 0;
    logic [4:0]  mark_sel = 0;
    logic        mark_kind = 0;

    always #10 clk = ~clk;

    seg_desc_cache dut (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_va(lk_va),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_word0(rsp_word0), .rsp_word1(rsp_word1),
        .fill_en(fill_en), .fill_va(fill_va), .fill_word0(fill_word0), .fill_word1(fill_word1),
        .inv_addr_en(inv_addr_en), .inv_addr_sel(inv_addr_sel),
        .inv_sec_en(inv_sec_en), .inv_sec_id(inv_sec_id), .inv_all_en(inv_all_en),
        .mark_en(mark_en), .mark_sel(mark_sel), .mark_kind(mark_kind)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit cmp_on = 0;
    string cur_req = "R1";

    // behavioural model
    bit          m_good [NE];
    bit          m_mod  [NE];
    logic [9:0]  m_tag  [NE];
    logic [31:0] m_w0   [NE];
    logic [31:0] m_w1   [NE];
    logic        e_valid = 0, e_hit = 0;
    logic [31:0] e_w0 = 0, e_w1 = 0;

    function automatic int sel_to_idx(input logic [4:0] s);
        return int'(s[4:3]) * 8 + int'(s[2:0]);
    endfunction

    function automatic logic [14:0] mk_va(input int sec, input int seg, input int tag);
        return {sec[1:0], seg[2:0], tag[9:0]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NE; i++) begin
                m_good[i] = 0; m_mod[i] = 0;
            end
            e_valid = 0; e_hit = 0; e_w0 = 0; e_w1 = 0;
        end else begin
            int k;
            e_valid = lk_req;
            e_hit = 0; e_w0 = 0; e_w1 = 0;
            if (lk_req) begin
                k = sel_to_idx(lk_va[14:10]);
                if (m_good[k] && m_tag[k] == lk_va[9:0]) begin
                    e_hit = 1;
                    e_w0 = m_w0[k] | (m_mod[k] ? 32'h2 : 32'h0);
                    e_w1 = m_w1[k];
                end
            end
            if (fill_en) begin
                k = sel_to_idx(fill_va[14:10]);
                m_good[k] = 1; m_tag[k] = fill_va[9:0];
                m_w0[k] = fill_word0; m_w1[k] = fill_word1; m_mod[k] = fill_word0[1];
            end
            if (mark_en && !mark_kind) m_mod[sel_to_idx(mark_sel)] = 1;
            if (inv_addr_en) m_good[sel_to_idx(inv_addr_sel)] = 0;
            if (inv_sec_en)
                for (int e = 0; e < 8; e++) m_good[int'(inv_sec_id) * 8 + e] = 0;
            if (inv_all_en)
                for (int i = 0; i < NE; i++) m_good[i] = 0;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            checks++;
            if (rsp_valid !== e_valid) begin
                failures++;
                $display("FAIL %s rsp_valid act=%0b exp=%0b", cur_req, rsp_valid, e_valid);
            end else if (e_valid) begin
                if (rsp_hit !== e_hit || rsp_word0 !== e_w0 || rsp_word1 !== e_w1) begin
                    failures++;
                    $display("FAIL %s rsp act=%0b/%h/%h exp=%0b/%h/%h", cur_req,
                             rsp_hit, rsp_word0, rsp_word1, e_hit, e_w0, e_w1);
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #2;
        lk_req = 0; fill_en = 0; inv_addr_en = 0; inv_sec_en = 0;
        inv_all_en = 0; mark_en = 0; mark_kind = 0;
    endtask

    task automatic do_fill(input int sec, input int seg, input int tag,
                           input logic [31:0] w0, input logic [31:0] w1);
        fill_en = 1; fill_va = mk_va(sec, seg, tag); fill_word0 = w0; fill_word1 = w1;
    endtask

    task automatic do_look(input int sec, input int seg, input int tag);
        lk_req = 1; lk_va = mk_va(sec, seg, tag);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        cmp_on = 1;
        // R1: reset state
        chk("R1 reset valid", {31'b0, rsp_valid}, 32'h0);
        for (int i = 0; i < NE; i++) begin
            do_look(i / 8, i % 8, 0); cyc();
            chk("R1 miss after reset", {31'b0, rsp_hit}, 32'h0);
        end

        // R5 / R2: fill then lookup
        cur_req = "R5";
        do_fill(2, 5, 10'h155, 32'hA5A5_0001, 32'h1234_5678); cyc();
        do_look(2, 5, 10'h155); cyc();
        chk("R5 hit", {31'b0, rsp_hit}, 32'h1);
        chk("R5 word0", rsp_word0, 32'hA5A5_0001);
        chk("R5 word1", rsp_word1, 32'h1234_5678);
        cur_req = "R2";
        do_look(2, 4, 10'h155); cyc();
        chk("R2 neighbour miss", {31'b0, rsp_hit}, 32'h0);
        for (int i = 0; i < NE; i++) begin
            do_fill(i / 8, i % 8, i * 7 + 1, 32'h1000_0000 + i * 32'h0101_0100, ~i); cyc();
        end
        for (int i = 0; i < NE; i++) begin
            do_look(i / 8, i % 8, i * 7 + 1); cyc();
        end

        // R3: tag mismatch misses with zero words
        cur_req = "R3";
        do_look(1, 3, 10'h3FF); cyc();
        chk("R3 tag miss", {31'b0, rsp_hit}, 32'h0);
        chk("R3 miss word0", rsp_word0, 32'h0);

        // R4: fill and lookup in same cycle see old state
        cur_req = "R4";
        inv_addr_en = 1; inv_addr_sel = 5'd9; cyc();
        do_fill(1, 1, 10'h0AA, 32'h0000_00F0, 32'h5); do_look(1, 1, 10'h0AA); cyc();
        chk("R4 same-cycle fill invisible", {31'b0, rsp_hit}, 32'h0);
        chk("R4 valid", {31'b0, rsp_valid}, 32'h1);
        do_look(1, 1, 10'h0AA); cyc();
        chk("R4 visible next", {31'b0, rsp_hit}, 32'h1);
        cyc();
        chk("R4 one-cycle strobe", {31'b0, rsp_valid}, 32'h0);

        // R6: address invalidate ignores tag
        cur_req = "R6";
        inv_addr_en = 1; inv_addr_sel = {2'd1, 3'd1}; cyc();
        do_look(1, 1, 10'h0AA); cyc();
        chk("R6 flushed", {31'b0, rsp_hit}, 32'h0);

        // R7: section invalidate
        cur_req = "R7";
        inv_sec_en = 1; inv_sec_id = 2'd3; cyc();
        for (int i = 16; i < NE; i++) begin
            do_look(i / 8, i % 8, i * 7 + 1); cyc();
        end
        do_look(3, 0, 3 * 8 * 7 + 1); cyc();
        chk("R7 section gone", {31'b0, rsp_hit}, 32'h0);
        do_look(2, 0, 2 * 8 * 7 + 1); cyc();
        chk("R7 other section kept", {31'b0, rsp_hit}, 32'h1);

        // R8: flush all
        cur_req = "R8";
        inv_all_en = 1; cyc();
        for (int i = 0; i < NE; i++) begin
            do_look(i / 8, i % 8, i * 7 + 1); cyc();
            chk("R8 all gone", {31'b0, rsp_hit}, 32'h0);
        end

        // R9: modified flag set regardless of tag
        cur_req = "R9";
        do_fill(2, 5, 10'h155, 32'hA5A5_0001, 32'h1234_5678); cyc();
        mark_en = 1; mark_kind = 0; mark_sel = {2'd2, 3'd5}; cyc();
        do_look(2, 5, 10'h155); cyc();
        chk("R9 modified set", rsp_word0, 32'hA5A5_0003);
        do_look(2, 5, 10'h155); cyc();
        chk("R9 sticky", rsp_word0, 32'hA5A5_0003);

        // R10: referenced request has no effect
        cur_req = "R10";
        do_fill(0, 0, 10'h003, 32'h0000_0010, 32'h77); cyc();
        mark_en = 1; mark_kind = 1; mark_sel = 5'd0; cyc();
        do_look(0, 0, 10'h003); cyc();
        chk("R10 word0 unchanged", rsp_word0, 32'h0000_0010);
        chk("R10 still hit", {31'b0, rsp_hit}, 32'h1);

        // R11: invalidate beats fill
        cur_req = "R11";
        do_fill(1, 6, 10'h011, 32'h1, 32'h2); inv_addr_en = 1; inv_addr_sel = {2'd1, 3'd6}; cyc();
        do_look(1, 6, 10'h011); cyc();
        chk("R11 addr beats fill", {31'b0, rsp_hit}, 32'h0);
        do_fill(0, 2, 10'h012, 32'h1, 32'h2); inv_sec_en = 1; inv_sec_id = 2'd0; cyc();
        do_look(0, 2, 10'h012); cyc();
        chk("R11 section beats fill", {31'b0, rsp_hit}, 32'h0);
        do_fill(3, 7, 10'h013, 32'h1, 32'h2); inv_all_en = 1; cyc();
        do_look(3, 7, 10'h013); cyc();
        chk("R11 all beats fill", {31'b0, rsp_hit}, 32'h0);

        // R12: fill plus modified mark
        cur_req = "R12";
        do_fill(3, 2, 10'h020, 32'hC000_0000, 32'h9); mark_en = 1; mark_kind = 0;
        mark_sel = {2'd3, 3'd2}; cyc();
        do_look(3, 2, 10'h020); cyc();
        chk("R12 hit", {31'b0, rsp_hit}, 32'h1);
        chk("R12 modified", rsp_word0, 32'hC000_0002);

        // mixed traffic checked against the model every cycle
        cur_req = "R2";
        for (int n = 0; n < 3000; n++) begin
            int s, g;
            s = $urandom_range(0, 3); g = $urandom_range(0, 7);
            if ($urandom_range(0, 1) == 1) do_look(s, g, $urandom_range(0, 3));
            if ($urandom_range(0, 2) == 0)
                do_fill($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 3),
                        $urandom, $urandom);
            if ($urandom_range(0, 9) == 0) begin
                inv_addr_en = 1; inv_addr_sel = 5'($urandom_range(0, 31));
            end
            if ($urandom_range(0, 39) == 0) begin
                inv_sec_en = 1; inv_sec_id = 2'($urandom_range(0, 3));
            end
            if ($urandom_range(0, 199) == 0) inv_all_en = 1;
            if ($urandom_range(0, 5) == 0) begin
                mark_en = 1; mark_kind = 1'($urandom_range(0, 1));
                mark_sel = 5'($urandom_range(0, 31));
            end
            cyc();
        end
        cyc();
        done = 1;
        summary();
        $finish;
    end
endmodule